// File: doc/BRIEF.md
# Set-Associative TLB Lookup

This block translates 32-bit virtual addresses to physical addresses over 4 KiB pages. A requester presents a virtual address, an access kind (read, write or instruction fetch) and the current process ID, together with a lookup strobe. The block searches every way of the set that the low bits of the virtual page number select. One clock later it returns a registered result: a clean-hit flag, the physical address, the read, write and execute permissions of the matching entry, and a permission-fault flag.

Entries live in a ways-by-sets array. A management write port fills that array, one entry per write. Each entry is made of a tag and a data word. The tag holds the page number, a global flag, a valid flag and the owning process ID. The data word holds the frame number and the three permission bits.

Page-table walking, caching and exception delivery sit outside the block.

Top module: `tlb_lookup`

## Requirements
- R1: While reset is held and after it is released, `rsp_valid_o`, `hit_o`, `fault_o`, the permission outputs and `paddr_o` are all zero. All entries start invalid.
- R2: `rsp_valid_o` is high in exactly the cycle after a cycle with `lookup_valid_i` high, and low otherwise.
- R3: An entry matches only when its valid flag is set and its stored page number equals `vaddr_i[31:12]`.
- R4: A matching entry whose global flag is set ignores the process ID. An entry with the global flag clear also needs its stored PID to equal `pid_i`.
- R5: When several ways of the selected set match, the lowest-numbered way supplies the result.
- R6: On a clean hit, `paddr_o` is the matched frame number in bits 31:12, followed by `vaddr_i[11:0]`.
- R7: `acc_i` 0 is read, 1 is write and 2 is fetch. Each is allowed by the entry's R, W or X bit respectively, and code 3 is never allowed. A match whose needed bit is clear gives `fault_o`=1, `hit_o`=0 and `paddr_o`=0.
- R8: With no match, `hit_o`, `fault_o`, `paddr_o` and all permission outputs are zero.
- R9: On `wr_en_i` the entry of way `wr_way_i` in set `wr_vpn_i[SET_W-1:0]` is replaced by the written fields. An entry never matches a lookup whose page number differs from its own.
- R10: On any match, clean or faulting, `perm_r_o`, `perm_w_o` and `perm_x_o` equal the matched entry's R, W and X bits. `wr_data_i` holds R in bit 22, W in bit 21, X in bit 20 and the frame number in bits 19:0.
- R11: In cycles that follow a cycle without a strobe, `hit_o`, `fault_o`, `paddr_o` and the permission outputs keep their values.
- R12: A lookup and a write in the same cycle see the array as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lookup_valid_i | input | 1 | Lookup strobe |
| vaddr_i | input | 32 | Virtual address |
| acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| pid_i | input | PID_W | Current process ID |
| wr_en_i | input | 1 | Entry write strobe |
| wr_way_i | input | WAY_W | Way to write |
| wr_vpn_i | input | 20 | Page number of the new entry; low bits pick the set |
| wr_global_i | input | 1 | Global flag of the new entry |
| wr_valid_i | input | 1 | Valid flag of the new entry |
| wr_pid_i | input | PID_W | Owning PID of the new entry |
| wr_data_i | input | 23 | {R, W, X, frame number[19:0]} |
| rsp_valid_o | output | 1 | Result valid, one cycle after the strobe |
| hit_o | output | 1 | Clean hit |
| fault_o | output | 1 | Match without permission for the access |
| paddr_o | output | 32 | Physical address on a clean hit, else zero |
| perm_r_o | output | 1 | Matched entry read permission |
| perm_w_o | output | 1 | Matched entry write permission |
| perm_x_o | output | 1 | Matched entry execute permission |

## Verification
Every lookup result is due exactly one clock after the edge that captures the strobe. A write takes effect at its own edge, so a lookup strobed in the same cycle still sees the old entry. The bench drives stimulus just after a falling edge. It updates its behavioural model at that same point, lookup first and write second, and then compares every output at the next falling edge. Because this compare runs on every cycle, both the one-cycle latency and the holding of outputs between strobes are checked continuously.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W   = 32;
  localparam int PAGE_W = 12;
  localparam int VPN_W  = VA_W - PAGE_W;
  localparam int PFN_W  = 20;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic             r;
    logic             w;
    logic             x;
    logic [PFN_W-1:0] pfn;
  } tlb_data_t;
endpackage

// File: rtl/tlb_way_store.sv
module tlb_way_store
  import tlb_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int PID_W = 8,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic             wr_global_i,
  input  logic             wr_valid_i,
  input  logic [PID_W-1:0] wr_pid_i,
  input  tlb_data_t        wr_data_i,
  input  logic [SET_W-1:0] rd_set_i,
  output logic [VPN_W-1:0] rd_vpn_o,
  output logic             rd_global_o,
  output logic             rd_valid_o,
  output logic [PID_W-1:0] rd_pid_o,
  output tlb_data_t        rd_data_o
);
  logic [VPN_W-1:0] vpn_q [SETS];
  logic [SETS-1:0]  glb_q;
  logic [SETS-1:0]  vld_q;
  logic [PID_W-1:0] pid_q [SETS];
  tlb_data_t        dat_q [SETS];

  logic [SET_W-1:0] wr_set;
  assign wr_set = wr_vpn_i[SET_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_q <= '0;
      vld_q <= '0;
      for (int s = 0; s < SETS; s++) begin
        vpn_q[s] <= '0;
        pid_q[s] <= '0;
        dat_q[s] <= '0;
      end
    end else if (wr_en_i) begin
      vpn_q[wr_set] <= wr_vpn_i;
      glb_q[wr_set] <= wr_global_i;
      vld_q[wr_set] <= wr_valid_i;
      pid_q[wr_set] <= wr_pid_i;
      dat_q[wr_set] <= wr_data_i;
    end
  end

  assign rd_vpn_o    = vpn_q[rd_set_i];
  assign rd_global_o = glb_q[rd_set_i];
  assign rd_valid_o  = vld_q[rd_set_i];
  assign rd_pid_o    = pid_q[rd_set_i];
  assign rd_data_o   = dat_q[rd_set_i];
endmodule

// File: rtl/tlb_tag_match.sv
module tlb_tag_match
  import tlb_pkg::*;
#(
  parameter int PID_W = 8
) (
  input  logic [VPN_W-1:0] ent_vpn_i,
  input  logic             ent_global_i,
  input  logic             ent_valid_i,
  input  logic [PID_W-1:0] ent_pid_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [PID_W-1:0] pid_i,
  output logic             match_o
);
  assign match_o = ent_valid_i && (ent_vpn_i == vpn_i) &&
                   (ent_global_i || (ent_pid_i == pid_i));
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  match_i,
  output logic             found_o,
  output logic [WAY_W-1:0] way_o
);
  always_comb begin
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_i[w]) way_o = WAY_W'(w);
    end
  end
  assign found_o = |match_i;
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_WAYS    = 4,
  parameter int PID_W       = 8,
  localparam int SETS  = NUM_ENTRIES / NUM_WAYS,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lookup_valid_i,
  input  logic [31:0]      vaddr_i,
  input  logic [1:0]       acc_i,
  input  logic [PID_W-1:0] pid_i,
  input  logic             wr_en_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [19:0]      wr_vpn_i,
  input  logic             wr_global_i,
  input  logic             wr_valid_i,
  input  logic [PID_W-1:0] wr_pid_i,
  input  logic [22:0]      wr_data_i,
  output logic             rsp_valid_o,
  output logic             hit_o,
  output logic             fault_o,
  output logic [31:0]      paddr_o,
  output logic             perm_r_o,
  output logic             perm_w_o,
  output logic             perm_x_o
);
  logic [VPN_W-1:0] vpn;
  logic [SET_W-1:0] set_idx;
  assign vpn     = vaddr_i[VA_W-1:PAGE_W];
  assign set_idx = vpn[SET_W-1:0];

  logic [NUM_WAYS-1:0] way_match;
  tlb_data_t           way_data [NUM_WAYS];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [VPN_W-1:0] e_vpn;
    logic             e_glb;
    logic             e_vld;
    logic [PID_W-1:0] e_pid;

    tlb_way_store #(.SETS(SETS), .PID_W(PID_W)) i_store (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i && (wr_way_i == WAY_W'(w))),
      .wr_vpn_i   (wr_vpn_i),
      .wr_global_i(wr_global_i),
      .wr_valid_i (wr_valid_i),
      .wr_pid_i   (wr_pid_i),
      .wr_data_i  (tlb_data_t'(wr_data_i)),
      .rd_set_i   (set_idx),
      .rd_vpn_o   (e_vpn),
      .rd_global_o(e_glb),
      .rd_valid_o (e_vld),
      .rd_pid_o   (e_pid),
      .rd_data_o  (way_data[w])
    );

    tlb_tag_match #(.PID_W(PID_W)) i_match (
      .ent_vpn_i   (e_vpn),
      .ent_global_i(e_glb),
      .ent_valid_i (e_vld),
      .ent_pid_i   (e_pid),
      .vpn_i       (vpn),
      .pid_i       (pid_i),
      .match_o     (way_match[w])
    );
  end

  logic             found;
  logic [WAY_W-1:0] sel_way;
  tlb_first_hit #(.WAYS(NUM_WAYS)) i_pick (
    .match_i(way_match),
    .found_o(found),
    .way_o  (sel_way)
  );

  tlb_data_t sel;
  logic      allowed;
  assign sel = way_data[sel_way];

  always_comb begin
    unique case (acc_e'(acc_i))
      ACC_READ:  allowed = sel.r;
      ACC_WRITE: allowed = sel.w;
      ACC_FETCH: allowed = sel.x;
      default:   allowed = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      fault_o     <= 1'b0;
      paddr_o     <= '0;
      perm_r_o    <= 1'b0;
      perm_w_o    <= 1'b0;
      perm_x_o    <= 1'b0;
    end else begin
      rsp_valid_o <= lookup_valid_i;
      if (lookup_valid_i) begin
        hit_o    <= found && allowed;
        fault_o  <= found && !allowed;
        paddr_o  <= (found && allowed) ? {sel.pfn, vaddr_i[PAGE_W-1:0]} : '0;
        perm_r_o <= found && sel.r;
        perm_w_o <= found && sel.w;
        perm_x_o <= found && sel.x;
      end
    end
  end
endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        lookup_valid_i,
  input logic [11:0] vaddr_lo_i,
  input logic [1:0]  acc_i,
  input logic        rsp_valid_o,
  input logic        hit_o,
  input logic        fault_o,
  input logic [31:0] paddr_o,
  input logic        perm_r_o,
  input logic        perm_w_o,
  input logic        perm_x_o
);
  assert_rsp_after_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> rsp_valid_o);

  assert_no_rsp_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |=> !rsp_valid_o);

  assert_hit_fault_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && fault_o));

  assert_no_hit_zero_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> paddr_o == 32'd0);

  assert_offset_passes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && hit_o) |-> paddr_o[11:0] == $past(vaddr_lo_i));

  assert_hit_has_perm_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && hit_o) |->
      (($past(acc_i) == 2'd0 && perm_r_o) || ($past(acc_i) == 2'd1 && perm_w_o) ||
       ($past(acc_i) == 2'd2 && perm_x_o)));

  assert_hold_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |=> ($stable(hit_o) && $stable(fault_o) && $stable(paddr_o) &&
                         $stable(perm_r_o) && $stable(perm_w_o) && $stable(perm_x_o)));
endmodule

bind tlb_lookup tlb_lookup_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lookup_valid_i(lookup_valid_i),
  .vaddr_lo_i    (vaddr_i[11:0]),
  .acc_i         (acc_i),
  .rsp_valid_o   (rsp_valid_o),
  .hit_o         (hit_o),
  .fault_o       (fault_o),
  .paddr_o       (paddr_o),
  .perm_r_o      (perm_r_o),
  .perm_w_o      (perm_w_o),
  .perm_x_o      (perm_x_o)
);

// File: tb/test_tlb_lookup.sv
`timescale 1ns/1ps
module test_tlb_lookup;
  localparam int ENT = 16, WAYS = 4, PIDW = 8;
  localparam int SETS = ENT / WAYS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lv = 1'b0, wen = 1'b0, wg = 1'b0, wv = 1'b0;
  logic [31:0] va = '0;
  logic [1:0]  acc = '0, wway = '0;
  logic [PIDW-1:0] pid = '0, wpid = '0;
  logic [19:0] wvpn = '0;
  logic [22:0] wdat = '0;
  logic rv, hit, flt, pr, pw, px;
  logic [31:0] pa;

  always #10 clk = ~clk;

  tlb_lookup #(.NUM_ENTRIES(ENT), .NUM_WAYS(WAYS), .PID_W(PIDW)) i_tlb_lookup (
    .clk_i(clk), .rst_ni(rst_n), .lookup_valid_i(lv), .vaddr_i(va), .acc_i(acc),
    .pid_i(pid), .wr_en_i(wen), .wr_way_i(wway), .wr_vpn_i(wvpn),
    .wr_global_i(wg), .wr_valid_i(wv), .wr_pid_i(wpid), .wr_data_i(wdat),
    .rsp_valid_o(rv), .hit_o(hit), .fault_o(flt), .paddr_o(pa),
    .perm_r_o(pr), .perm_w_o(pw), .perm_x_o(px));

  // behavioural model
  logic [19:0] m_vpn [WAYS][SETS];
  logic        m_g   [WAYS][SETS];
  logic        m_v   [WAYS][SETS];
  logic [PIDW-1:0] m_pid [WAYS][SETS];
  logic [22:0] m_dat [WAYS][SETS];
  logic e_rv = 0, e_hit = 0, e_flt = 0, e_pr = 0, e_pw = 0, e_px = 0;
  logic [31:0] e_pa = '0;
  int checks = 0, fails = 0;

  task automatic model_step();
    e_rv = lv;
    if (lv) begin
      int s = int'(va[31:12]) % SETS;
      int found = -1;
      for (int w = 0; w < WAYS; w++)
        if (found < 0 && m_v[w][s] && m_vpn[w][s] == va[31:12] &&
            (m_g[w][s] || m_pid[w][s] == pid)) found = w;
      if (found < 0) begin
        {e_hit, e_flt, e_pr, e_pw, e_px} = '0; e_pa = '0;
      end else begin
        logic [22:0] d = m_dat[found][s];
        logic ok = (acc == 0) ? d[22] : (acc == 1) ? d[21] : (acc == 2) ? d[20] : 1'b0;
        e_hit = ok; e_flt = !ok;
        e_pr = d[22]; e_pw = d[21]; e_px = d[20];
        e_pa = ok ? {d[19:0], va[11:0]} : 32'd0;
      end
    end
    if (wen) begin
      int s = int'(wvpn) % SETS;
      m_vpn[wway][s] = wvpn; m_g[wway][s] = wg; m_v[wway][s] = wv;
      m_pid[wway][s] = wpid; m_dat[wway][s] = wdat;
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if ({rv, hit, flt, pr, pw, px, pa} !== {e_rv, e_hit, e_flt, e_pr, e_pw, e_px, e_pa}) begin
      fails++;
      $display("FAIL %s: got v=%b h=%b f=%b rwx=%b%b%b pa=%h, exp v=%b h=%b f=%b rwx=%b%b%b pa=%h",
               tag, rv, hit, flt, pr, pw, px, pa, e_rv, e_hit, e_flt, e_pr, e_pw, e_px, e_pa);
    end
  endtask

  task automatic tick(input string tag);
    model_step();
    @(negedge clk);
    compare(tag);
    lv = 0; wen = 0;
  endtask

  task automatic wr(input int way, input logic [19:0] vpn, input logic g, input logic v,
                    input logic [PIDW-1:0] p, input logic [22:0] d);
    wen = 1; wway = way[1:0]; wvpn = vpn; wg = g; wv = v; wpid = p; wdat = d;
    tick("R9 write");
  endtask

  task automatic look(input logic [31:0] a, input logic [1:0] k, input logic [PIDW-1:0] p,
                      input string tag);
    lv = 1; va = a; acc = k; pid = p;
    tick(tag);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int w = 0; w < WAYS; w++)
      for (int s = 0; s < SETS; s++) begin
        m_vpn[w][s] = '0; m_g[w][s] = 0; m_v[w][s] = 0; m_pid[w][s] = '0; m_dat[w][s] = '0;
      end
    @(negedge clk); compare("R1 in reset");
    @(negedge clk); rst_n = 1;
    @(negedge clk); compare("R1 after reset");
    look(32'h0000_0123, 2'd0, 8'd0, "R1 R3 empty array misses");
    // way0 set1: vpn 1, pid 5, R+W, pfn ABCDE
    wr(0, 20'h00001, 0, 1, 8'd5, {3'b110, 20'hABCDE});
    look(32'h0000_1234, 2'd0, 8'd5, "R6 read hit");
    look(32'h0000_1FFF, 2'd1, 8'd5, "R7 write allowed");
    look(32'h0000_1000, 2'd2, 8'd5, "R7 fetch fault");
    look(32'h0000_1000, 2'd3, 8'd5, "R7 code 3 faults");
    look(32'h0000_1234, 2'd0, 8'd6, "R4 pid mismatch miss");
    look(32'h0000_5234, 2'd0, 8'd5, "R3 R9 other vpn same set");
    // global exec-only entry way1 set2
    wr(1, 20'h12342, 1, 1, 8'd9, {3'b001, 20'h00777});
    look(32'h1234_2ABC, 2'd2, 8'd33, "R4 global any pid");
    look(32'h1234_2ABC, 2'd0, 8'd9, "R10 read fault perms");
    tick("R11 idle hold");
    tick("R11 idle hold 2");
    // priority in set3
    wr(2, 20'h00003, 1, 1, 8'd0, {3'b111, 20'h22222});
    wr(3, 20'h00003, 1, 1, 8'd0, {3'b111, 20'h33333});
    look(32'h0000_3010, 2'd0, 8'd1, "R5 lowest way wins");
    wr(2, 20'h00003, 1, 0, 8'd0, {3'b111, 20'h22222});
    look(32'h0000_3010, 2'd1, 8'd1, "R3 R5 invalid way skipped");
    // replace way0 set1 with vpn 0x11; same-cycle lookup sees old
    lv = 1; va = 32'h0000_1004; acc = 2'd0; pid = 8'd5;
    wen = 1; wway = 2'd0; wvpn = 20'h00011; wg = 0; wv = 1; wpid = 8'd5;
    wdat = {3'b100, 20'h0BEEF};
    tick("R12 lookup before write");
    look(32'h0000_1004, 2'd0, 8'd5, "R9 replaced entry misses");
    look(32'h0001_1004, 2'd0, 8'd5, "R9 new entry hits");
    look(32'h0001_1004, 2'd1, 8'd5, "R7 R10 write fault");
    tick("R2 R11 final idle");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule